// File: doc/BRIEF.md
# Protection Interrupt Status and Enable Aggregator

This block gathers the interrupt status lines of a group of peripheral protection controllers and memory protection controllers into status words that software can read. Each peripheral protection controller has one fixed bit in a shared status layout, and the same bit position is used in the enable word and the clear word. The block keeps an interrupt-enable register. From it, and from writes to a clear register, the block drives one enable line and one clear line back to each peripheral protection controller.

The peripheral controllers form three groups: two internal APB controllers at bits 0 and 1, up to four APB expansion controllers starting at bit 4, and up to four AHB expansion controllers starting at bit 20. The internal memory protection controller reports at bit 0 of its own status word, and expansion controller n reports at bit 16+n. A bridge-interrupt enable register can be written and read back. The bridge status word always reads zero, because bridge errors are never reported.

Software reaches the block through a plain 32-bit register port. Read data is combinational from the address. A write takes effect only when it is flagged as a full-word access.

Top module: `secirq_agg`

## Requirements
- R1: After reset, the enable register and the bridge-enable register read zero, and every enable output and every clear output is low.
- R2: A read at offset 0x20 returns the live peripheral status inputs placed at these bits: internal controller 0 at bit 0, internal controller 1 at bit 1, APB expansion i at bit 4+i, AHB expansion i at bit 20+i. All other bits read zero.
- R3: A read at offset 0x1C returns the internal memory protection status at bit 0 and expansion status n at bit 16+n. All other bits read zero.
- R4: A full-word write to offset 0x28 stores only the bits of the valid enable mask (0x00F000F3 in the default configuration), and a read at 0x28 returns the stored value.
- R5: Each enable output equals its controller's bit of the enable register. It changes in the clock cycle after the write is captured and holds its value when there is no enable write.
- R6: A full-word write to offset 0x24 drives each controller's clear output high for exactly one cycle, in the cycle after the write, when that controller's bit in the written data is set. Clear outputs are low at all other times.
- R7: A full-word write to offset 0x48 keeps only bits [31:16] in the bridge-enable register, and reads at 0x48 return it. A read at offset 0x40 returns zero.
- R8: A write with the full-word flag low changes no register and produces no clear pulse.
- R9: Writes to the status offsets 0x1C, 0x20 and 0x40 change nothing. Reads at 0x24 and at unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_word | input | 1 | High when the access is a full 32-bit word |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| ppc_stat | input | 2+N_APBX+N_AHBX | Peripheral controller status levels: internal 0, internal 1, APB expansion, then AHB expansion |
| mpc_stat_int | input | 1 | Internal memory protection controller status |
| mpc_stat_exp | input | N_MPCX | Expansion memory protection controller status |
| ppc_irq_en | output | 2+N_APBX+N_AHBX | Per-controller interrupt enable, in the same order as ppc_stat |
| ppc_irq_clr | output | 2+N_APBX+N_AHBX | Per-controller one-cycle clear pulse, in the same order as ppc_stat |

## Verification
The case that is hardest to reach from the ports is a clear pulse that must appear for only one cycle and then drop while the enable state stays untouched. The bench writes one-hot and mixed clear words at every mapped position and at the unmapped bits between the groups. It samples the clear lines in the cycle after each write and again in the cycle after that. Narrow writes and writes to status offsets follow a non-zero enable setting, so that any stray change in the register file would appear on the enable outputs.

// File: rtl/secirq_pkg.sv
package secirq_pkg;
  localparam logic [11:0] OFS_MPC_STAT = 12'h01C;
  localparam logic [11:0] OFS_PPC_STAT = 12'h020;
  localparam logic [11:0] OFS_PPC_CLR  = 12'h024;
  localparam logic [11:0] OFS_PPC_EN   = 12'h028;
  localparam logic [11:0] OFS_BRG_STAT = 12'h040;
  localparam logic [11:0] OFS_BRG_EN   = 12'h048;

  localparam logic [31:0] BRG_EN_MASK  = 32'hFFFF_0000;
  localparam int unsigned APBX_BASE    = 4;
  localparam int unsigned AHBX_BASE    = 20;
  localparam int unsigned MPCX_BASE    = 16;

  // Bit position in the shared word for controller k (internal, APB exp, AHB exp)
  function automatic logic [4:0] ppc_pos(input int unsigned k, input int unsigned n_apbx);
    int unsigned p;
    if (k < 2) p = k;
    else if (k < 2 + n_apbx) p = APBX_BASE + (k - 2);
    else p = AHBX_BASE + (k - 2 - n_apbx);
    return 5'(p);
  endfunction

  function automatic logic [31:0] ppc_mask(input int unsigned n_apbx, input int unsigned n_ahbx);
    logic [31:0] m;
    m = '0;
    for (int unsigned k = 0; k < 2 + n_apbx + n_ahbx; k++) m[ppc_pos(k, n_apbx)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/secirq_ppc_gather.sv
module secirq_ppc_gather
  import secirq_pkg::*;
#(
  parameter int unsigned N_APBX = 4,
  parameter int unsigned N_AHBX = 4,
  localparam int unsigned NPPC = 2 + N_APBX + N_AHBX
) (
  input  logic [NPPC-1:0] lines,
  output logic [31:0]     word
);
  always_comb begin
    word = '0;
    for (int unsigned k = 0; k < NPPC; k++) word[ppc_pos(k, N_APBX)] = lines[k];
  end
endmodule

// File: rtl/secirq_ppc_scatter.sv
module secirq_ppc_scatter
  import secirq_pkg::*;
#(
  parameter int unsigned N_APBX = 4,
  parameter int unsigned N_AHBX = 4,
  localparam int unsigned NPPC = 2 + N_APBX + N_AHBX
) (
  input  logic [31:0]     word,
  output logic [NPPC-1:0] lines
);
  for (genvar k = 0; k < NPPC; k++) begin : g_line
    assign lines[k] = word[ppc_pos(k, N_APBX)];
  end
endmodule

// File: rtl/secirq_regs.sv
module secirq_regs
  import secirq_pkg::*;
#(
  parameter int unsigned N_APBX = 4,
  parameter int unsigned N_AHBX = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_word,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic [31:0] ppc_word,
  input  logic [31:0] mpc_word,
  output logic [31:0] reg_rdata,
  output logic [31:0] en_word,
  output logic [31:0] clr_word,
  output logic        en_wr_evt,
  output logic        clr_wr_evt
);
  localparam logic [31:0] EN_MASK = ppc_mask(N_APBX, N_AHBX);

  logic        wr_ok;
  logic        brg_wr_evt;
  logic [31:0] en_q, brg_q, clr_q;

  assign wr_ok      = reg_wr && reg_word;
  assign en_wr_evt  = wr_ok && (reg_addr == OFS_PPC_EN);
  assign clr_wr_evt = wr_ok && (reg_addr == OFS_PPC_CLR);
  assign brg_wr_evt = wr_ok && (reg_addr == OFS_BRG_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      brg_q <= '0;
      clr_q <= '0;
    end else begin
      if (en_wr_evt)  en_q  <= reg_wdata & EN_MASK;
      if (brg_wr_evt) brg_q <= reg_wdata & BRG_EN_MASK;
      clr_q <= clr_wr_evt ? (reg_wdata & EN_MASK) : '0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_MPC_STAT: reg_rdata = mpc_word;
      OFS_PPC_STAT: reg_rdata = ppc_word;
      OFS_PPC_EN:   reg_rdata = en_q;
      OFS_BRG_EN:   reg_rdata = brg_q;
      default:      reg_rdata = '0;
    endcase
  end

  assign en_word  = en_q;
  assign clr_word = clr_q;
endmodule

// File: rtl/secirq_agg.sv
module secirq_agg
  import secirq_pkg::*;
#(
  parameter int unsigned N_APBX = 4,
  parameter int unsigned N_AHBX = 4,
  parameter int unsigned N_MPCX = 4,
  localparam int unsigned NPPC = 2 + N_APBX + N_AHBX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_word,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NPPC-1:0]   ppc_stat,
  input  logic              mpc_stat_int,
  input  logic [N_MPCX-1:0] mpc_stat_exp,
  output logic [NPPC-1:0]   ppc_irq_en,
  output logic [NPPC-1:0]   ppc_irq_clr
);
  logic [31:0] ppc_word, mpc_word, en_word, clr_word;
  logic        en_wr_evt, clr_wr_evt;

  always_comb begin
    mpc_word    = '0;
    mpc_word[0] = mpc_stat_int;
    for (int unsigned n = 0; n < N_MPCX; n++) mpc_word[MPCX_BASE + n] = mpc_stat_exp[n];
  end

  secirq_ppc_gather #(.N_APBX(N_APBX), .N_AHBX(N_AHBX)) u_gather (
    .lines(ppc_stat), .word(ppc_word)
  );

  secirq_regs #(.N_APBX(N_APBX), .N_AHBX(N_AHBX)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ppc_word(ppc_word),
    .mpc_word(mpc_word), .reg_rdata(reg_rdata), .en_word(en_word),
    .clr_word(clr_word), .en_wr_evt(en_wr_evt), .clr_wr_evt(clr_wr_evt)
  );

  secirq_ppc_scatter #(.N_APBX(N_APBX), .N_AHBX(N_AHBX)) u_en_fan (
    .word(en_word), .lines(ppc_irq_en)
  );

  secirq_ppc_scatter #(.N_APBX(N_APBX), .N_AHBX(N_AHBX)) u_clr_fan (
    .word(clr_word), .lines(ppc_irq_clr)
  );
endmodule

// File: rtl/secirq_agg_chk.sv
module secirq_agg_chk
  import secirq_pkg::*;
#(
  parameter int unsigned N_APBX = 4,
  parameter int unsigned N_AHBX = 4,
  localparam int unsigned NPPC = 2 + N_APBX + N_AHBX
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic            reg_word,
  input logic [11:0]     reg_addr,
  input logic [31:0]     reg_rdata,
  input logic [NPPC-1:0] ppc_irq_en,
  input logic [NPPC-1:0] ppc_irq_clr,
  input logic            en_wr_evt,
  input logic            clr_wr_evt
);
  localparam logic [31:0] EN_MASK = ppc_mask(N_APBX, N_AHBX);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (ppc_irq_en == '0 && ppc_irq_clr == '0)); // R1
  AST_EN_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_PPC_EN) |-> ((reg_rdata & ~EN_MASK) == '0)); // R4
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_evt |=> $stable(ppc_irq_en)); // R5
  AST_CLR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ppc_irq_clr != '0) |-> $past(clr_wr_evt)); // R6
  AST_BRG_STAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_BRG_STAT) |-> (reg_rdata == '0)); // R7
  AST_NARROW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_word) |=> ($stable(ppc_irq_en) && ppc_irq_clr == '0)); // R8
endmodule

bind secirq_agg secirq_agg_chk #(.N_APBX(N_APBX), .N_AHBX(N_AHBX)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .ppc_irq_en(ppc_irq_en),
  .ppc_irq_clr(ppc_irq_clr), .en_wr_evt(en_wr_evt), .clr_wr_evt(clr_wr_evt)
);

// File: tb/tb_secirq_agg.sv
module tb_secirq_agg;
  localparam int CLK_PERIOD = 10;
  localparam int NPPC = 10;
  localparam int NMPC = 4;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            reg_wr = 0, reg_word = 0;
  logic [11:0]     reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NPPC-1:0] ppc_stat = '0;
  logic            mpc_stat_int = 0;
  logic [NMPC-1:0] mpc_stat_exp = '0;
  logic [NPPC-1:0] ppc_irq_en, ppc_irq_clr;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secirq_agg #(.N_APBX(4), .N_AHBX(4), .N_MPCX(NMPC)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ppc_stat(ppc_stat), .mpc_stat_int(mpc_stat_int), .mpc_stat_exp(mpc_stat_exp),
    .ppc_irq_en(ppc_irq_en), .ppc_irq_clr(ppc_irq_clr)
  );

  // Expected bit of controller k: 0,1 then 4..7 then 20..23
  function automatic int bpos(int k);
    if (k < 2) return k;
    if (k < 6) return k + 2;
    return k + 14;
  endfunction

  function automatic logic [NPPC-1:0] pick(logic [31:0] w);
    logic [NPPC-1:0] v;
    for (int k = 0; k < NPPC; k++) v[k] = w[bpos(k)];
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Entered and left at a negedge; on return the write is one edge old
  task automatic wr(logic [11:0] a, logic [31:0] d, logic word);
    reg_addr = a; reg_wdata = d; reg_wr = 1; reg_word = word;
    @(negedge clk);
    reg_wr = 0; reg_word = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ew;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 en outputs", 32'(ppc_irq_en), 0);
    chk("R1 clr outputs", 32'(ppc_irq_clr), 0);
    rst_n = 1;
    @(negedge clk);
    rd(12'h028, d); chk("R1 enable reg", d, 0);
    rd(12'h048, d); chk("R1 bridge enable reg", d, 0);

    // R2 exhaustive status sweep
    for (int p = 0; p < (1 << NPPC); p++) begin
      ppc_stat = NPPC'(p);
      ew = 0;
      for (int k = 0; k < NPPC; k++) if (p[k]) ew |= 32'(1) << bpos(k);
      rd(12'h020, d); chk("R2 ppc status", d, ew);
    end
    // R3 exhaustive MPC sweep
    for (int p = 0; p < 32; p++) begin
      mpc_stat_int = p[0];
      mpc_stat_exp = NMPC'(p >> 1);
      ew = 32'(p[0]) | (32'(p >> 1) << 16);
      rd(12'h01C, d); chk("R3 mpc status", d, ew);
    end

    // R4 R5 walking enable bits
    @(negedge clk);
    for (int b = 0; b < 32; b++) begin
      wr(12'h028, 32'(1) << b, 1);
      ew = (32'(1) << b) & 32'h00F000F3;
      rd(12'h028, d); chk("R4 enable readback", d, ew);
      chk("R5 enable outputs", 32'(ppc_irq_en), 32'(pick(ew)));
    end
    wr(12'h028, 32'hFFFFFFFF, 1);
    rd(12'h028, d); chk("R4 enable all-ones", d, 32'h00F000F3);
    wr(12'h028, 32'hA5A5A5A5, 1);
    ew = 32'hA5A5A5A5 & 32'h00F000F3;
    chk("R5 enable pattern", 32'(ppc_irq_en), 32'(pick(ew)));
    @(negedge clk);
    chk("R5 enable holds", 32'(ppc_irq_en), 32'(pick(ew)));

    // R6 clear pulses per bit
    for (int b = 0; b < 32; b++) begin
      wr(12'h024, 32'(1) << b, 1);
      chk("R6 clear pulse", 32'(ppc_irq_clr), 32'(pick(32'(1) << b)));
      @(negedge clk);
      chk("R6 clear drops", 32'(ppc_irq_clr), 0);
    end
    wr(12'h024, 32'h00500031, 1);
    chk("R6 clear mixed", 32'(ppc_irq_clr), 32'(pick(32'h00500031)));
    chk("R6 enable untouched by clear", 32'(ppc_irq_en), 32'(pick(ew)));
    @(negedge clk);
    chk("R6 clear mixed drops", 32'(ppc_irq_clr), 0);

    // R7 bridge
    wr(12'h048, 32'h1234ABCD, 1);
    rd(12'h048, d); chk("R7 bridge enable", d, 32'h12340000);
    rd(12'h040, d); chk("R7 bridge status", d, 0);

    // R8 narrow writes ignored
    wr(12'h028, 32'hFFFFFFFF, 0);
    chk("R8 narrow enable out", 32'(ppc_irq_en), 32'(pick(ew)));
    rd(12'h028, d); chk("R8 narrow enable reg", d, ew);
    wr(12'h024, 32'hFFFFFFFF, 0);
    chk("R8 narrow clear", 32'(ppc_irq_clr), 0);
    wr(12'h048, 32'hFFFFFFFF, 0);
    rd(12'h048, d); chk("R8 narrow bridge", d, 32'h12340000);

    // R9 read-only and unmapped
    ppc_stat = '0; mpc_stat_int = 0; mpc_stat_exp = '0;
    wr(12'h020, 32'hFFFFFFFF, 1);
    wr(12'h01C, 32'hFFFFFFFF, 1);
    wr(12'h040, 32'hFFFFFFFF, 1);
    rd(12'h020, d); chk("R9 ppc status unchanged", d, 0);
    rd(12'h01C, d); chk("R9 mpc status unchanged", d, 0);
    rd(12'h040, d); chk("R9 bridge status", d, 0);
    chk("R9 enable out unchanged", 32'(ppc_irq_en), 32'(pick(ew)));
    rd(12'h028, d); chk("R9 enable reg unchanged", d, ew);
    rd(12'h024, d); chk("R9 clear reads zero", d, 0);
    rd(12'h100, d); chk("R9 unmapped reads zero", d, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule